// File: doc/BRIEF.md
# Sleep-Time Receive Wake Filter

This block watches the byte-wide receive stream of an Ethernet port while the host sleeps. It copies every received byte unchanged to a memory write path one cycle later. At the end of each frame it gives a one-cycle keep/drop verdict, so the write path can either commit the stored frame or throw it away. Frames that no enabled rule claims are dropped without involving the host. Background traffic therefore never wakes the system, and no frame aimed at this host is lost.

Two accept rules are built in, and each has its own enable. The first matches an address-resolution request whose target protocol address is this host's IPv4 address. The second matches a unicast frame sent to this host's MAC address. When a frame is kept while sleep mode is enabled, a wake level is set. That level stays high until software pulses the clear input.

Top module: `rxw_wake_filter`

## Requirements
- R1: Every byte accepted on the input (`rx_valid` high) appears on the output one cycle later, with the same data and the same start and end markers. `fwd_valid` is low in every cycle that follows a cycle without an input byte.
- R2: `verdict_valid` is high for exactly one cycle, in the cycle where the frame's last byte is on the output (`fwd_eof` high). At all other times it is low. `verdict_keep` is high only together with `verdict_valid`.
- R3: With `cfg_arp_en` set, a frame is kept when all of these hold. Bytes 12..13 are 0x08,0x06. Bytes 14..15 are 0x00,0x01. Bytes 16..17 are 0x08,0x00. Bytes 20..21 are 0x00,0x01 (request). Bytes 38..41 equal `cfg_host_ip`, with byte 38 holding bits 31:24.
- R4: An address-resolution frame is dropped when its target address differs from `cfg_host_ip`. It is also dropped when its opcode is not 1, for example 2 (reply).
- R5: With `cfg_ucast_en` set, a frame is kept when bytes 0..5 equal `cfg_host_mac`, with byte 0 holding bits 47:40, and bit 0 of byte 0 is clear. A group-addressed destination such as all-ones is not kept by this rule.
- R6: A frame that matches only a rule whose enable is clear is dropped.
- R7: A frame whose last byte carries `rx_err` is dropped, whatever rules it matches.
- R8: A frame that ends before byte 41 never matches the address-resolution rule.
- R9: `wake` rises in the cycle after a kept verdict, but only while `cfg_sleep_en` is high. A dropped frame, or a kept frame with sleep mode off, leaves `wake` low.
- R10: `wake` stays high until a `wake_clr` pulse, and falls in the cycle after that pulse. When a new set and a clear fall in the same cycle, the set wins.
- R11: After reset `fwd_valid`, `verdict_valid`, `verdict_keep` and `wake` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Input byte valid |
| rx_data | input | 8 | Input byte |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_err | input | 1 | Receive error, read together with the last byte |
| cfg_host_mac | input | 48 | Local MAC address |
| cfg_host_ip | input | 32 | Local IPv4 address |
| cfg_arp_en | input | 1 | Enable for the address-resolution rule |
| cfg_ucast_en | input | 1 | Enable for the unicast destination rule |
| cfg_sleep_en | input | 1 | Sleep mode; kept frames set wake |
| wake_clr | input | 1 | Software clear pulse for wake |
| fwd_valid | output | 1 | Forwarded byte valid |
| fwd_data | output | 8 | Forwarded byte |
| fwd_sof | output | 1 | Forwarded first byte |
| fwd_eof | output | 1 | Forwarded last byte |
| verdict_valid | output | 1 | End-of-frame verdict strobe |
| verdict_keep | output | 1 | 1 = keep and commit, 0 = drop |
| wake | output | 1 | Sticky wake request |

## Verification
A byte driven in cycle N is on the forwarded output in cycle N+1. The verdict for a frame appears in the same N+1 cycle as its last byte. The wake level follows one cycle later, at N+2, and a clear pulse takes effect one cycle after it is applied. The bench drives inputs on the falling edge and samples on the next falling edge, so exactly one rising edge separates stimulus from sample. Each check is placed at the cycle this count gives, and the cycle after the verdict is checked to show the strobe has gone low again.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  localparam int unsigned IDX_W    = 8;
  localparam int unsigned ETH_HDR  = 14;
  localparam int unsigned TPA_OFS  = ETH_HDR + 24;
  localparam int unsigned ARP_LAST = TPA_OFS + 3;
  localparam int unsigned MAC_LAST = 5;

  typedef struct packed {
    logic       care;
    logic [7:0] val;
  } byte_rule_t;

  // Expected byte for an address-resolution request at frame index idx.
  function automatic byte_rule_t arp_rule(input logic [IDX_W-1:0] idx,
                                          input logic [31:0] ip);
    byte_rule_t r;
    r.care = 1'b1;
    r.val  = 8'h00;
    case (int'(idx))
      12: r.val = 8'h08;
      13: r.val = 8'h06;
      14: r.val = 8'h00;
      15: r.val = 8'h01;
      16: r.val = 8'h08;
      17: r.val = 8'h00;
      20: r.val = 8'h00;
      21: r.val = 8'h01;
      TPA_OFS:     r.val = ip[31:24];
      TPA_OFS + 1: r.val = ip[23:16];
      TPA_OFS + 2: r.val = ip[15:8];
      TPA_OFS + 3: r.val = ip[7:0];
      default: r.care = 1'b0;
    endcase
    return r;
  endfunction

  // Expected destination byte for the unicast rule.
  function automatic byte_rule_t mac_rule(input logic [IDX_W-1:0] idx,
                                          input logic [47:0] mac);
    byte_rule_t r;
    r.care = 1'b1;
    r.val  = 8'h00;
    case (int'(idx))
      0: r.val = mac[47:40];
      1: r.val = mac[39:32];
      2: r.val = mac[31:24];
      3: r.val = mac[23:16];
      4: r.val = mac[15:8];
      5: r.val = mac[7:0];
      default: r.care = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rxw_field_match.sv
module rxw_field_match
  import rxw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic [7:0]  in_data,
  input  logic [47:0] cfg_mac,
  input  logic [31:0] cfg_ip,
  output logic        arp_hit,
  output logic        ucast_hit
);

  localparam logic [IDX_W-1:0] IDX_MAX    = '1;
  localparam logic [IDX_W-1:0] ARP_LAST_I = IDX_W'(ARP_LAST);
  localparam logic [IDX_W-1:0] MAC_LAST_I = IDX_W'(MAC_LAST);

  logic [IDX_W-1:0] idx_q, idx_cur;
  logic             arp_bad_q, mac_bad_q;
  logic             arp_bad_cur, mac_bad_cur;
  byte_rule_t       ar, mr;

  always_comb begin
    idx_cur = in_sof ? '0 : idx_q;
    ar = arp_rule(idx_cur, cfg_ip);
    mr = mac_rule(idx_cur, cfg_mac);
    arp_bad_cur = (in_sof ? 1'b0 : arp_bad_q) | (ar.care && (in_data != ar.val));
    mac_bad_cur = (in_sof ? 1'b0 : mac_bad_q) | (mr.care && (in_data != mr.val))
                | ((idx_cur == '0) && in_data[0]);
    arp_hit   = !arp_bad_cur && (idx_cur >= ARP_LAST_I);
    ucast_hit = !mac_bad_cur && (idx_cur >= MAC_LAST_I);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      arp_bad_q <= 1'b0;
      mac_bad_q <= 1'b0;
    end else if (in_valid) begin
      idx_q     <= (idx_cur == IDX_MAX) ? idx_cur : idx_cur + 1'b1;
      arp_bad_q <= arp_bad_cur;
      mac_bad_q <= mac_bad_cur;
    end
  end

endmodule

// File: rtl/rxw_verdict.sv
module rxw_verdict (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_eof,
  input  logic in_err,
  input  logic arp_hit,
  input  logic ucast_hit,
  input  logic arp_en,
  input  logic ucast_en,
  output logic verdict_valid,
  output logic verdict_keep
);

  logic ev_frame_end;
  logic ev_accept;

  assign ev_frame_end = in_valid && in_eof;
  assign ev_accept    = ev_frame_end && !in_err &&
                        ((arp_en && arp_hit) || (ucast_en && ucast_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_valid <= 1'b0;
      verdict_keep  <= 1'b0;
    end else begin
      verdict_valid <= ev_frame_end;
      verdict_keep  <= ev_accept;
    end
  end

  assert_err_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eof && in_err) |=> !verdict_keep);

  assert_keep_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_keep |-> verdict_valid);

  assert_pulse_only_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_eof) |=> !verdict_valid);

endmodule

// File: rtl/rxw_wake_latch.sv
module rxw_wake_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic sleep_en,
  input  logic clr,
  output logic wake
);

  logic ev_wake_set;

  assign ev_wake_set = accept && sleep_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake <= 1'b0;
    else        wake <= ev_wake_set | (wake & ~clr);
  end

  assert_wake_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake) |-> $past(accept && sleep_en));

  assert_wake_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !clr) |=> wake);

  assert_wake_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(accept && sleep_en)) |=> !wake);

endmodule

// File: rtl/rxw_wake_filter.sv
module rxw_wake_filter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic        rx_err,
  input  logic [47:0] cfg_host_mac,
  input  logic [31:0] cfg_host_ip,
  input  logic        cfg_arp_en,
  input  logic        cfg_ucast_en,
  input  logic        cfg_sleep_en,
  input  logic        wake_clr,
  output logic        fwd_valid,
  output logic [7:0]  fwd_data,
  output logic        fwd_sof,
  output logic        fwd_eof,
  output logic        verdict_valid,
  output logic        verdict_keep,
  output logic        wake
);

  logic arp_hit, ucast_hit;

  rxw_field_match u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rx_valid),
    .in_sof    (rx_sof),
    .in_data   (rx_data),
    .cfg_mac   (cfg_host_mac),
    .cfg_ip    (cfg_host_ip),
    .arp_hit   (arp_hit),
    .ucast_hit (ucast_hit)
  );

  rxw_verdict u_verdict (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (rx_valid),
    .in_eof        (rx_eof),
    .in_err        (rx_err),
    .arp_hit       (arp_hit),
    .ucast_hit     (ucast_hit),
    .arp_en        (cfg_arp_en),
    .ucast_en      (cfg_ucast_en),
    .verdict_valid (verdict_valid),
    .verdict_keep  (verdict_keep)
  );

  rxw_wake_latch u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (verdict_keep),
    .sleep_en (cfg_sleep_en),
    .clr      (wake_clr),
    .wake     (wake)
  );

  // Forwarded stream: one register stage, aligned with the verdict.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_data  <= '0;
      fwd_sof   <= 1'b0;
      fwd_eof   <= 1'b0;
    end else begin
      fwd_valid <= rx_valid;
      fwd_data  <= rx_data;
      fwd_sof   <= rx_valid && rx_sof;
      fwd_eof   <= rx_valid && rx_eof;
    end
  end

  assert_passthrough_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (fwd_valid && fwd_data == $past(rx_data)));

  assert_verdict_on_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> (fwd_valid && fwd_eof));

endmodule

// File: tb/tb_rxw_wake_filter.sv
module tb_rxw_wake_filter;

  localparam logic [47:0] HOST_MAC = 48'h02_1A_2B_3C_4D_5E;
  localparam logic [31:0] HOST_IP  = 32'hC0_A8_01_42;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        cfg_arp_en = 1'b0, cfg_ucast_en = 1'b0, cfg_sleep_en = 1'b0;
  logic        wake_clr = 1'b0;
  logic        fwd_valid, fwd_sof, fwd_eof, verdict_valid, verdict_keep, wake;
  logic [7:0]  fwd_data;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] fr [0:63];

  always #2 clk = ~clk;

  rxw_wake_filter dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
    .cfg_host_mac(HOST_MAC), .cfg_host_ip(HOST_IP),
    .cfg_arp_en(cfg_arp_en), .cfg_ucast_en(cfg_ucast_en),
    .cfg_sleep_en(cfg_sleep_en), .wake_clr(wake_clr),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_sof(fwd_sof),
    .fwd_eof(fwd_eof), .verdict_valid(verdict_valid),
    .verdict_keep(verdict_keep), .wake(wake)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void build_arp(input logic [7:0] oper, input logic [31:0] tpa);
    for (int i = 0; i < 64; i++) fr[i] = 8'(i * 7);
    for (int i = 0; i < 6; i++) fr[i] = 8'hFF;
    fr[12] = 8'h08; fr[13] = 8'h06; fr[14] = 8'h00; fr[15] = 8'h01;
    fr[16] = 8'h08; fr[17] = 8'h00; fr[18] = 8'h06; fr[19] = 8'h04;
    fr[20] = 8'h00; fr[21] = oper;
    fr[38] = tpa[31:24]; fr[39] = tpa[23:16]; fr[40] = tpa[15:8]; fr[41] = tpa[7:0];
  endfunction

  function automatic void build_ucast(input logic [47:0] dmac);
    for (int i = 0; i < 64; i++) fr[i] = 8'(i + 3);
    for (int i = 0; i < 6; i++) fr[i] = dmac[47-8*i -: 8];
    fr[12] = 8'h08; fr[13] = 8'h00;
  endfunction

  // Sends fr[0..len-1]; returns after the negedge where the verdict is due.
  task automatic send(input int len, input bit err, input bit exp_keep, input string req);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk(fwd_valid && fwd_data == fr[i-1], "R1 data", int'(fwd_data), int'(fr[i-1]));
        chk(fwd_sof == (i == 1), "R1 sof", int'(fwd_sof), int'(i == 1));
        chk(!verdict_valid, "R2 early", int'(verdict_valid), 0);
      end
      rx_valid = 1'b1; rx_data = fr[i];
      rx_sof = (i == 0); rx_eof = (i == len - 1); rx_err = err && (i == len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    chk(fwd_eof && fwd_data == fr[len-1], "R1 last", int'(fwd_data), int'(fr[len-1]));
    chk(verdict_valid, "R2 strobe", int'(verdict_valid), 1);
    chk(verdict_keep == exp_keep, req, int'(verdict_keep), int'(exp_keep));
  endtask

  task automatic idle_after(input bit exp_wake, input string req);
    @(negedge clk);
    chk(!verdict_valid && !verdict_keep, "R2 one cycle", int'(verdict_valid), 0);
    chk(!fwd_valid, "R1 idle", int'(fwd_valid), 0);
    chk(wake == exp_wake, req, int'(wake), int'(exp_wake));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!fwd_valid && !verdict_valid && !verdict_keep && !wake, "R11 reset", int'(wake), 0);
  endtask

  task automatic t_arp;
    cfg_arp_en = 1'b1; cfg_ucast_en = 1'b0; cfg_sleep_en = 1'b0;
    build_arp(8'h01, HOST_IP);      send(60, 1'b0, 1'b1, "R3 arp keep");
    idle_after(1'b0, "R9 no wake when awake");
    build_arp(8'h01, HOST_IP ^ 32'h1); send(60, 1'b0, 1'b0, "R4 wrong tpa");
    idle_after(1'b0, "R9 no wake");
    build_arp(8'h02, HOST_IP);      send(60, 1'b0, 1'b0, "R4 reply");
    idle_after(1'b0, "R9 no wake");
    build_arp(8'h01, HOST_IP);      send(42, 1'b0, 1'b1, "R3 min length");
    idle_after(1'b0, "R9 no wake");
    build_arp(8'h01, HOST_IP);      send(40, 1'b0, 1'b0, "R8 short");
    idle_after(1'b0, "R9 no wake");
  endtask

  task automatic t_ucast;
    cfg_arp_en = 1'b0; cfg_ucast_en = 1'b1;
    build_ucast(HOST_MAC);          send(60, 1'b0, 1'b1, "R5 ucast keep");
    idle_after(1'b0, "R9 no wake");
    build_ucast(48'hFFFF_FFFF_FFFF); send(60, 1'b0, 1'b0, "R5 group drop");
    idle_after(1'b0, "R9 no wake");
    build_ucast(HOST_MAC ^ 48'h100); send(60, 1'b0, 1'b0, "R5 other mac");
    idle_after(1'b0, "R9 no wake");
  endtask

  task automatic t_enables;
    cfg_arp_en = 1'b0; cfg_ucast_en = 1'b1;
    build_arp(8'h01, HOST_IP);      send(60, 1'b0, 1'b0, "R6 arp disabled");
    idle_after(1'b0, "R9 no wake");
    cfg_arp_en = 1'b1; cfg_ucast_en = 1'b0;
    build_ucast(HOST_MAC);          send(60, 1'b0, 1'b0, "R6 ucast disabled");
    idle_after(1'b0, "R9 no wake");
  endtask

  task automatic t_err;
    cfg_arp_en = 1'b1; cfg_ucast_en = 1'b1; cfg_sleep_en = 1'b1;
    build_arp(8'h01, HOST_IP);      send(60, 1'b1, 1'b0, "R7 err drop");
    idle_after(1'b0, "R9 err no wake");
  endtask

  task automatic t_wake;
    cfg_arp_en = 1'b1; cfg_ucast_en = 1'b0; cfg_sleep_en = 1'b1;
    build_arp(8'h01, HOST_IP ^ 32'h100); send(60, 1'b0, 1'b0, "R4 drop asleep");
    idle_after(1'b0, "R9 drop no wake");
    build_arp(8'h01, HOST_IP);      send(60, 1'b0, 1'b1, "R3 keep asleep");
    idle_after(1'b1, "R9 wake set");
    repeat (5) @(negedge clk);
    chk(wake, "R10 sticky", int'(wake), 1);
    wake_clr = 1'b1;
    @(negedge clk); wake_clr = 1'b0;
    chk(!wake, "R10 clear", int'(wake), 0);
    build_arp(8'h01, HOST_IP);      send(60, 1'b0, 1'b1, "R3 keep again");
    wake_clr = 1'b1;                // clear coincides with the set
    @(negedge clk); wake_clr = 1'b0;
    chk(wake, "R10 set wins", int'(wake), 1);
    wake_clr = 1'b1;
    @(negedge clk); wake_clr = 1'b0;
    chk(!wake, "R10 clear again", int'(wake), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_arp();
    t_ucast();
    t_enables();
    t_err();
    t_wake();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule